// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block is the memory-side fetch engine of a processor front end. It keeps a small byte FIFO stocked with instruction bytes. It does this on its own, without waiting for the execution side, which pulls bytes out in order whenever it needs them. Each fetch address is formed from a 16-bit code segment and a 16-bit fetch offset. The segment is scaled by sixteen, the offset is added to it, and the result is a 20-bit physical address covering a 1 MB space.

Reads go out one byte at a time over a request/acknowledge interface. Data comes back in request order on a valid strobe. The unit throttles itself: it stops asking for bytes once the bytes already queued plus the useful reads still in flight would fill the queue. It also caps the number of outstanding reads. A flush, as on a taken branch, loads a new segment and offset and empties the queue. It also marks every read still outstanding as stale, so that the data those reads return is dropped instead of queued.

Top module: `ifetch_queue`

## Requirements
- R1: Bytes leave the queue in exactly the order their read requests were accepted. A byte is removed only in a cycle where `popReq` is high and `popValid` is high, and `popData` shows the oldest byte.
- R2: `memAddr` equals `{seg,4'h0} + {4'h0,offset}` truncated to 20 bits, so a sum above FFFFFh wraps around to the bottom of the space.
- R3: `qLevel` never exceeds 6, and `memReq` is low whenever the queued bytes plus the non-stale reads in flight total 6.
- R4: The fetch offset advances by one for each accepted request (`memReq` and `memAck` both high). It wraps from FFFFh to 0000h, and the segment does not change.
- R5: While `flush` is high, `memReq` is low. In the following cycle `qLevel` is 0, `popValid` is low and `memAddr` reflects `newSeg`/`newOffset`.
- R6: Read data that returns for a request accepted before a flush is discarded and never reaches `popData`.
- R7: A push from memory and a pop in the same cycle are both performed, and `qLevel` is unchanged.
- R8: `popValid` is low exactly when the queue is empty, and a `popReq` on an empty queue leaves `qLevel` at 0.
- R9: After reset the queue is empty, the address is segment FFFFh offset 0000h (FFFF0h), and fetching starts at once.
- R10: No more than 4 reads are ever outstanding. With no data returning, a fresh empty queue issues exactly 4 requests and then stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Reload address and empty the queue |
| newSeg | input | 16 | Code segment loaded on flush |
| newOffset | input | 16 | Fetch offset loaded on flush |
| memReq | output | 1 | Byte read request |
| memAck | input | 1 | Memory accepts the current request |
| memAddr | output | 20 | Physical address of the current request |
| memRdValid | input | 1 | Returned read data is valid |
| memRdData | input | 8 | Returned read byte |
| popReq | input | 1 | Consumer takes the head byte |
| popValid | output | 1 | Queue holds at least one byte |
| popData | output | 8 | Head byte of the queue |
| qLevel | output | 3 | Number of queued bytes |

## Verification
The assertions rely on memory returning exactly one valid strobe per accepted read, in request order, and never returning more reads than it has accepted. The outstanding and stale counters are meaningful only under that contract. The bench memory model holds accepted addresses in an ordered list and raises `memRdValid` only for entries accepted on an earlier edge. Its data is a fixed function of the address, so every popped byte can be predicted from the accepted-address log. Flushes are applied while reads are in flight, so stale returns arrive after the reload.

// File: rtl/ifq_pkg.sv
package ifq_pkg;

  typedef struct packed {
    logic pushEn;    // write returned byte into the queue
    logic popEn;     // remove head byte
    logic flushEn;   // reload address, clear pointers
    logic fetchAdv;  // request accepted, advance offset
  } ifqStrobe_t;

  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int PADR_W = 20;
  localparam int BYTE_W = 8;

endpackage

// File: rtl/ifq_datapath.sv
module ifq_datapath
  import ifq_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter logic [SEG_W-1:0] RESET_SEG = 16'hFFFF,
  parameter logic [OFF_W-1:0] RESET_OFF = 16'h0000,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ifqStrobe_t        strobe,
  input  logic [SEG_W-1:0]  newSeg,
  input  logic [OFF_W-1:0]  newOffset,
  input  logic [BYTE_W-1:0] wrData,
  output logic [PADR_W-1:0] fetchAddr,
  output logic [BYTE_W-1:0] headData
);

  logic [SEG_W-1:0]  segReg;
  logic [OFF_W-1:0]  offReg;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [BYTE_W-1:0] store [DEPTH];

  function automatic logic [PTR_W-1:0] ptrNext(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + PTR_W'(1);
  endfunction

  // Segment and offset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      segReg <= RESET_SEG;
      offReg <= RESET_OFF;
    end else if (strobe.flushEn) begin
      segReg <= newSeg;
      offReg <= newOffset;
    end else if (strobe.fetchAdv) begin
      offReg <= offReg + OFF_W'(1);
    end
  end

  // Physical address: scaled segment plus offset, modulo 2^20
  logic [PADR_W-1:0] segBase;
  logic [PADR_W-1:0] offExt;
  always_comb begin
    segBase   = {segReg, 4'h0};
    offExt    = PADR_W'(offReg);
    fetchAddr = segBase + offExt;
  end

  // Queue pointers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (strobe.flushEn) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.pushEn) wrPtr <= ptrNext(wrPtr);
      if (strobe.popEn)  rdPtr <= ptrNext(rdPtr);
    end
  end

  // Queue storage, one register per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobe.pushEn && !strobe.flushEn && wrPtr == PTR_W'(i))
        store[i] <= wrData;
    end
  end

  assign headData = store[rdPtr];

  // Offset advances by exactly one per accepted fetch
  p_offset_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.fetchAdv && !strobe.flushEn) |=> (offReg == $past(offReg) + OFF_W'(1)));

  // Segment changes only on a flush
  p_seg_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.flushEn |=> $stable(segReg));

  // Flush lands the new address
  p_flush_load_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flushEn |=> (segReg == $past(newSeg) && offReg == $past(newOffset)));

endmodule

// File: rtl/ifq_control.sv
module ifq_control
  import ifq_pkg::*;
#(
  parameter int DEPTH       = 6,
  parameter int MAX_PENDING = 4,
  localparam int LVL_W  = $clog2(DEPTH + 1),
  localparam int PEND_W = $clog2(MAX_PENDING + 1),
  localparam int SUM_W  = ((LVL_W > PEND_W) ? LVL_W : PEND_W) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             memAck,
  input  logic             memRdValid,
  input  logic             popReq,
  output logic             memReq,
  output logic             popValid,
  output logic [LVL_W-1:0] level,
  output ifqStrobe_t       strobe
);

  logic [PEND_W-1:0] pending;   // all accepted, not yet returned
  logic [PEND_W-1:0] staleCnt;  // oldest outstanding reads to discard
  logic [PEND_W-1:0] goodPend;
  logic [SUM_W-1:0]  committed;
  logic              accept;
  logic              dropRd;

  always_comb begin
    goodPend  = pending - staleCnt;
    committed = SUM_W'(level) + SUM_W'(goodPend);
    memReq    = !flush && (committed < SUM_W'(DEPTH))
                && (pending < PEND_W'(MAX_PENDING));
    accept    = memReq && memAck;
    dropRd    = memRdValid && (staleCnt != '0);
    popValid  = (level != '0);

    strobe.flushEn  = flush;
    strobe.fetchAdv = accept;
    strobe.pushEn   = memRdValid && (staleCnt == '0) && !flush;
    strobe.popEn    = popReq && popValid && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= '0;
      staleCnt <= '0;
      level    <= '0;
    end else begin
      pending <= pending + PEND_W'(accept) - PEND_W'(memRdValid);
      if (flush) begin
        staleCnt <= pending - PEND_W'(memRdValid);
        level    <= '0;
      end else begin
        staleCnt <= staleCnt - PEND_W'(dropRd);
        level    <= level + LVL_W'(strobe.pushEn) - LVL_W'(strobe.popEn);
      end
    end
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVL_W'(DEPTH));

  p_no_req_full_r3: assert property (@(posedge clk) disable iff (!rstN)
    (committed >= SUM_W'(DEPTH)) |-> !memReq);

  p_push_room_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushEn |-> (level < LVL_W'(DEPTH) || strobe.popEn));

  p_pending_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    pending <= PEND_W'(MAX_PENDING));

  p_flush_no_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    flush |-> !memReq);

  p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (level == '0 && !popValid));

  p_stale_drop_r6: assert property (@(posedge clk) disable iff (!rstN)
    (staleCnt != '0 && memRdValid) |-> !strobe.pushEn);

  p_simul_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.pushEn && strobe.popEn) |=> (level == $past(level)));

  p_empty_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !strobe.popEn);

endmodule

// File: rtl/ifetch_queue.sv
module ifetch_queue
  import ifq_pkg::*;
#(
  parameter int DEPTH       = 6,
  parameter int MAX_PENDING = 4,
  parameter logic [15:0] RESET_SEG = 16'hFFFF,
  parameter logic [15:0] RESET_OFF = 16'h0000,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic [15:0]      newSeg,
  input  logic [15:0]      newOffset,
  output logic             memReq,
  input  logic             memAck,
  output logic [19:0]      memAddr,
  input  logic             memRdValid,
  input  logic [7:0]       memRdData,
  input  logic             popReq,
  output logic             popValid,
  output logic [7:0]       popData,
  output logic [LVL_W-1:0] qLevel
);

  ifqStrobe_t strobe;

  ifq_control #(
    .DEPTH      (DEPTH),
    .MAX_PENDING(MAX_PENDING)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .flush     (flush),
    .memAck    (memAck),
    .memRdValid(memRdValid),
    .popReq    (popReq),
    .memReq    (memReq),
    .popValid  (popValid),
    .level     (qLevel),
    .strobe    (strobe)
  );

  ifq_datapath #(
    .DEPTH    (DEPTH),
    .RESET_SEG(RESET_SEG),
    .RESET_OFF(RESET_OFF)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .newSeg   (newSeg),
    .newOffset(newOffset),
    .wrData   (memRdData),
    .fetchAddr(memAddr),
    .headData (popData)
  );

endmodule

// File: tb/tb_ifetch_queue.sv
module tb_ifetch_queue;

  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic [15:0] newSeg = '0;
  logic [15:0] newOffset = '0;
  logic        memReq;
  logic        memAck = 1'b1;
  logic [19:0] memAddr;
  logic        memRdValid = 1'b0;
  logic [7:0]  memRdData = '0;
  logic        popReq = 1'b0;
  logic        popValid;
  logic [7:0]  popData;
  logic [2:0]  qLevel;

  int nChecks = 0;
  int nFails  = 0;
  bit respEn  = 1'b0;
  string dataTag = "R1";

  logic [19:0] memQ[$];     // addresses awaiting return
  logic [7:0]  expQ[$];     // bytes expected at pop, current epoch
  logic [19:0] acceptLog[$];

  ifetch_queue dut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], 4'h5};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One clock: called just after a falling edge, returns after the next one.
  task automatic cycle();
    bit acc, rv, pv;
    logic [19:0] a;
    if (respEn && memQ.size() > 0) begin
      memRdValid = 1'b1;
      memRdData  = memByte(memQ[0]);
    end else begin
      memRdValid = 1'b0;
    end
    #1;
    acc = memReq && memAck;
    a   = memAddr;
    rv  = memRdValid;
    pv  = popValid;
    if (flush) check(!memReq, "R5", "memReq during flush", memReq, 0);
    check(qLevel <= 3'd6, "R3", "level bound", qLevel, 6);
    if (popReq && pv && !flush) begin
      logic [7:0] e;
      e = (expQ.size() > 0) ? expQ.pop_front() : 8'hxx;
      check(popData === e, dataTag, "pop order", popData, e);
    end
    if (flush) expQ.delete();
    @(posedge clk);
    if (rv) void'(memQ.pop_front());
    if (acc) begin
      memQ.push_back(a);
      expQ.push_back(memByte(a));
      acceptLog.push_back(a);
    end
    @(negedge clk);
    memRdValid = 1'b0;
  endtask

  task automatic doFlush(input logic [15:0] s, input logic [15:0] o);
    flush = 1'b1; newSeg = s; newOffset = o;
    cycle();
    flush = 1'b0;
    acceptLog.delete();
    #1;
    check(qLevel == 0, "R5", "level after flush", qLevel, 0);
    check(!popValid, "R5", "popValid after flush", popValid, 0);
    check(memAddr == (({4'h0, s} << 4) + 20'(o)), "R5", "addr after flush",
          memAddr, ({4'h0, s} << 4) + 20'(o));
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic t_reset();
    #1;
    check(qLevel == 0, "R9", "reset level", qLevel, 0);
    check(!popValid, "R9", "reset popValid", popValid, 0);
    check(memAddr == 20'hFFFF0, "R9", "reset addr", memAddr, 20'hFFFF0);
    check(memReq, "R9", "reset fetch", memReq, 1);
  endtask

  task automatic t_fill_drain();
    dataTag = "R1";
    memAck = 1'b1; respEn = 1'b1;
    doFlush(16'h0100, 16'h0010);
    run(20);
    #1;
    check(qLevel == 6, "R3", "full level", qLevel, 6);
    check(!memReq, "R3", "no request when full", memReq, 0);
    check(acceptLog.size() == 6, "R3", "requests issued", acceptLog.size(), 6);
    check(acceptLog[5] == 20'h01015, "R4", "sixth address", acceptLog[5], 20'h01015);
    respEn = 1'b0; memAck = 1'b0;
    popReq = 1'b1;
    run(6);
    #1;
    check(qLevel == 0 && !popValid, "R8", "drained", qLevel, 0);
    run(2);
    #1;
    check(qLevel == 0, "R8", "pop on empty", qLevel, 0);
    check(!popValid, "R8", "popValid empty", popValid, 0);
    popReq = 1'b0;
  endtask

  task automatic t_pending_simul();
    dataTag = "R7";
    respEn = 1'b0; memAck = 1'b1;
    doFlush(16'h2000, 16'h0000);
    run(8);
    check(acceptLog.size() == 4, "R10", "outstanding cap", acceptLog.size(), 4);
    memAck = 1'b0; respEn = 1'b1;
    run(2);
    #1;
    check(qLevel == 2, "R7", "level before simul", qLevel, 2);
    popReq = 1'b1;
    cycle();
    #1;
    check(qLevel == 2, "R7", "level after push+pop", qLevel, 2);
    respEn = 1'b0;
    run(2);
    #1;
    check(qLevel == 0, "R7", "drain after simul", qLevel, 0);
    popReq = 1'b0;
    respEn = 1'b1;
    run(3);
    popReq = 1'b1;
    run(3);
    popReq = 1'b0;
  endtask

  task automatic t_offset_wrap();
    respEn = 1'b1; memAck = 1'b1;
    doFlush(16'h1234, 16'hFFFE);
    run(5);
    check(acceptLog.size() >= 3, "R4", "wrap accepts", acceptLog.size(), 3);
    check(acceptLog[0] == 20'h2233E, "R4", "addr 0", acceptLog[0], 20'h2233E);
    check(acceptLog[1] == 20'h2233F, "R4", "addr 1", acceptLog[1], 20'h2233F);
    check(acceptLog[2] == 20'h12340, "R4", "offset wrap", acceptLog[2], 20'h12340);
    dataTag = "R1";
    popReq = 1'b1; memAck = 1'b0;
    run(8);
    popReq = 1'b0;
  endtask

  task automatic t_phys_wrap();
    respEn = 1'b0; memAck = 1'b1;
    doFlush(16'hFFFF, 16'h0020);
    run(2);
    check(acceptLog[0] == 20'h00010, "R2", "phys wrap", acceptLog[0], 20'h00010);
    check(acceptLog[1] == 20'h00011, "R2", "phys wrap+1", acceptLog[1], 20'h00011);
  endtask

  task automatic t_flush_stale();
    dataTag = "R6";
    respEn = 1'b0; memAck = 1'b1;
    doFlush(16'h3000, 16'h0040);
    run(3);
    respEn = 1'b1;
    doFlush(16'h4000, 16'h0080);
    run(16);
    #1;
    check(qLevel == 6, "R6", "level new epoch", qLevel, 6);
    memAck = 1'b0;
    popReq = 1'b1;
    run(6);
    popReq = 1'b0;
    #1;
    check(qLevel == 0, "R6", "stale not queued", qLevel, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_fill_drain();
    t_pending_simul();
    t_offset_wrap();
    t_phys_wrap();
    t_flush_stale();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule